// File: doc/BRIEF.md
# Accumulator Arithmetic and Bit-Test Unit

This unit performs the arithmetic step of an 8-bit accumulator machine. On each execute strobe it takes the accumulator value, a memory operand and an operation select. It combines them with the carry flag it holds itself. It then registers the new accumulator value, a one-cycle accumulator write enable, and the next sign (N), overflow (V), zero (Z) and carry (C) flags.

Three operations exist: add with carry, subtract with borrow, and bit test. For subtract, the held carry acts as an inverted borrow. Bit test only changes flags. The fourth select code is reserved and does nothing. Outside execute cycles, every register keeps its value. The surrounding core keeps the accumulator and writes it back when `acc_we_o` is high.

Top module: `acc_alu8`

## Requirements
- R1: After a synchronous reset, `result_o` is 0, `acc_we_o` is 0 and all four flags are 0.
- R2: Select 2'b00 (add) yields `result_o` = low 8 bits of A + M + C. C becomes the carry out of bit 7.
- R3: After add, V is bit 7 of (not(A xor M) and (A xor result)).
- R4: Select 2'b01 (subtract) yields the low 8 bits of A − M − (1 − C). C becomes 1 when the true difference is in 0..255 and 0 when it is negative.
- R5: After subtract, V is bit 7 of ((A xor M) and (A xor result)).
- R6: For every accumulator-writing operation, N equals bit 7 of the new result, and Z is 1 exactly when that result is zero.
- R7: Select 2'b10 (bit test) sets Z when (A and M) is zero, copies M bit 7 into N and M bit 6 into V, and keeps C. It leaves `acc_we_o` low and `result_o` unchanged.
- R8: When `exec_i` is low, the flags and `result_o` keep their values and `acc_we_o` is 0.
- R9: Select 2'b11 is reserved. With `exec_i` high it changes no flag and no result, and keeps `acc_we_o` low.
- R10: The results of an execute cycle appear on the clock edge where `exec_i` is sampled high. `acc_we_o` is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe |
| op_i | input | 2 | Operation select: 00 add, 01 subtract, 10 bit test, 11 reserved |
| acc_i | input | 8 | Current accumulator value (A) |
| opnd_i | input | 8 | Memory operand (M) |
| result_o | output | 8 | Registered new accumulator value |
| acc_we_o | output | 1 | Accumulator write enable, one cycle per writing execute |
| flag_n_o | output | 1 | Sign flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The carry that feeds each operation is internal state, and no port can set it directly. The stimulus therefore steers it with earlier operations: an add that wraps past 255 sets it, a subtract that borrows clears it. The vector table is ordered so that each subtract runs with a known carry, and both borrow-in cases are covered, including a borrow that produces a signed overflow. Bit-test and reserved vectors come between writing operations, so the check that they keep C and `result_o` has a non-zero earlier state to compare against.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_BIT  = 2'b10,
    OP_NONE = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu8_core.sv
module acc_alu8_core
  import acc_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  alu_flags_t     cur_f,
  output logic [W-1:0]   res,
  output alu_flags_t     nxt_f,
  output logic           wr
);
  localparam int XW = W + 1;

  logic [XW-1:0] sum_x;
  logic [XW-1:0] dif_x;
  logic [W-1:0]  sum_r;
  logic [W-1:0]  dif_r;

  assign sum_x = {1'b0, a} + {1'b0, m} + {{W{1'b0}}, cur_f.c};
  assign dif_x = {1'b0, a} - {1'b0, m} - {{W{1'b0}}, ~cur_f.c};
  assign sum_r = sum_x[W-1:0];
  assign dif_r = dif_x[W-1:0];

  always_comb begin
    res   = a;
    nxt_f = cur_f;
    wr    = 1'b0;
    unique case (op)
      OP_ADD: begin
        res     = sum_r;
        wr      = 1'b1;
        nxt_f.c = sum_x[W];
        nxt_f.v = (~(a[W-1] ^ m[W-1])) & (a[W-1] ^ sum_r[W-1]);
        nxt_f.n = sum_r[W-1];
        nxt_f.z = (sum_r == '0);
      end
      OP_SUB: begin
        res     = dif_r;
        wr      = 1'b1;
        nxt_f.c = ~dif_x[W];
        nxt_f.v = (a[W-1] ^ m[W-1]) & (a[W-1] ^ dif_r[W-1]);
        nxt_f.n = dif_r[W-1];
        nxt_f.z = (dif_r == '0);
      end
      OP_BIT: begin
        nxt_f.z = ((a & m) == '0);
        nxt_f.n = m[W-1];
        nxt_f.v = m[W-2];
      end
      default: begin
        nxt_f = cur_f;
      end
    endcase
  end
endmodule

// File: rtl/acc_alu8_state.sv
module acc_alu8_state
  import acc_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec,
  input  logic [W-1:0] res_d,
  input  alu_flags_t   flags_d,
  input  logic         wr_d,
  output logic [W-1:0] res_q,
  output alu_flags_t   flags_q,
  output logic         we_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= exec & wr_d;
      if (exec) begin
        flags_q <= flags_d;
        if (wr_d) res_q <= res_d;
      end
    end
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] result_o,
  output logic         acc_we_o,
  output logic         flag_n_o,
  output logic         flag_v_o,
  output logic         flag_z_o,
  output logic         flag_c_o
);
  alu_flags_t   flags_q;
  alu_flags_t   flags_d;
  logic [W-1:0] res_d;
  logic         wr_d;

  acc_alu8_core #(.W(W)) u_core (
    .op    (alu_op_e'(op_i)),
    .a     (acc_i),
    .m     (opnd_i),
    .cur_f (flags_q),
    .res   (res_d),
    .nxt_f (flags_d),
    .wr    (wr_d)
  );

  acc_alu8_state #(.W(W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .exec    (exec_i),
    .res_d   (res_d),
    .flags_d (flags_d),
    .wr_d    (wr_d),
    .res_q   (result_o),
    .flags_q (flags_q),
    .we_q    (acc_we_o)
  );

  assign flag_n_o = flags_q.n;
  assign flag_v_o = flags_q.v;
  assign flag_z_o = flags_q.z;
  assign flag_c_o = flags_q.c;

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> ($stable(flags_q) && $stable(result_o) && !acc_we_o));

  a_r7_bit_flags: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 2'b10) |=> (flag_n_o == $past(opnd_i[W-1]) &&
      flag_v_o == $past(opnd_i[W-2]) && $stable(flag_c_o) &&
      $stable(result_o) && !acc_we_o));

  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 2'b11) |=> ($stable(flags_q) && $stable(result_o) && !acc_we_o));

  a_r6_nz_match: assert property (@(posedge clk) disable iff (rst)
    acc_we_o |-> (flag_n_o == result_o[W-1] && flag_z_o == (result_o == '0)));

  a_r10_we_pulse: assert property (@(posedge clk) disable iff (rst)
    (exec_i && !op_i[1]) |=> acc_we_o);
endmodule

// File: tb/test_acc_alu8.sv
module test_acc_alu8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] result_o;
  logic       acc_we_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu8 #(.W(8)) i_acc_alu8 (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .result_o(result_o), .acc_we_o(acc_we_o),
    .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_z_o(flag_z_o),
    .flag_c_o(flag_c_o)
  );

  // {op, A, M, expected result, expected we, expected {N,V,Z,C}}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {2'b00, 8'h10, 8'h20, 8'h30, 1'b1, 4'b0000}, // R2 plain add
    {2'b00, 8'hFF, 8'h01, 8'h00, 1'b1, 4'b0011}, // R2 R6 wrap, carry out, zero
    {2'b00, 8'h50, 8'h50, 8'hA1, 1'b1, 4'b1100}, // R3 signed overflow, carry in
    {2'b01, 8'h50, 8'h10, 8'h3F, 1'b1, 4'b0001}, // R4 borrow in (C=0)
    {2'b01, 8'h05, 8'h05, 8'h00, 1'b1, 4'b0011}, // R4 R6 zero difference
    {2'b01, 8'h00, 8'h01, 8'hFF, 1'b1, 4'b1000}, // R4 negative -> C cleared
    {2'b01, 8'h80, 8'h00, 8'h7F, 1'b1, 4'b0101}, // R5 overflow via borrow
    {2'b10, 8'h0F, 8'hC0, 8'h7F, 1'b0, 4'b1111}, // R7 disjoint, N V from M
    {2'b10, 8'h01, 8'h01, 8'h7F, 1'b0, 4'b0001}, // R7 overlap
    {2'b11, 8'h12, 8'h34, 8'h7F, 1'b0, 4'b0001}, // R9 reserved
    {2'b00, 8'h7F, 8'h7F, 8'hFF, 1'b1, 4'b1100}, // R3 overflow with carry in
    {2'b01, 8'h80, 8'h7F, 8'h00, 1'b1, 4'b0111}  // R5 overflow, zero
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int flags_now();
    return {flag_n_o, flag_v_o, flag_z_o, flag_c_o};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 result", result_o, 0);
    check("R1 we", acc_we_o, 0);
    check("R1 flags", flags_now(), 0);

    for (int i = 0; i < NV; i++) begin
      op_i   = VEC[i][30:29];
      acc_i  = VEC[i][28:21];
      opnd_i = VEC[i][20:13];
      exec_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exec_i = 1'b0;
      check($sformatf("R2-R9 vec%0d result", i), result_o, VEC[i][12:5]);
      check($sformatf("R10 vec%0d we", i), acc_we_o, VEC[i][4]);
      check($sformatf("R6 vec%0d flags", i), flags_now(), VEC[i][3:0]);
    end

    // R10: write enable drops one cycle after the strobe
    @(negedge clk);
    check("R10 we pulse end", acc_we_o, 0);

    // R8: inputs that would change everything, without the strobe
    op_i = 2'b00; acc_i = 8'hFF; opnd_i = 8'hFF;
    repeat (2) @(negedge clk);
    check("R8 result held", result_o, 8'h00);
    check("R8 flags held", flags_now(), 4'b0111);
    check("R8 we low", acc_we_o, 0);

    // R1: reset in mid run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid result", result_o, 0);
    check("R1 mid flags", flags_now(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule